// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block sits on the memory side of a small shared-memory system and carries out indivisible read-modify-write requests from several requesters against a word-addressed storage array. It provides plain load and store, test-and-set, swap, and a reserve/conditional-store pair. It also keeps one reservation per requester, which any write by another requester can cancel. This is the effect an invalidation would have in a coherent system.

Every requester presents a valid bit, an opcode, an address and write data. A fixed-priority arbiter grants one request per cycle, and the lowest requester ID wins. Requesters that are not granted hold their request until they are. The control is a two-state machine. ST_IDLE moves to ST_RESP when a request is accepted. ST_RESP stays in ST_RESP when another request is accepted in the same cycle, and returns to ST_IDLE otherwise. The response is valid while the machine is in ST_RESP. A mode input chooses how reservations are kept. With the mode low, a reservation is tied to an address. With the mode high, a reservation is a bare flag.

Opcode encoding on each 3-bit field: 0 load, 1 store, 2 test-and-set, 3 swap, 4 load-reserved, 5 store-conditional. Codes 6 and 7 act as a load.

Top module: `amo_unit`

## Requirements
- R1: After reset rsp_valid and every grant are low, every memory word reads 0, and every reservation is clear, so a store-conditional issued first fails.
- R2: Among the asserted request valids, only the lowest ID is granted in a cycle. The others see grant low and must hold their request until they are granted.
- R3: rsp_valid is high in exactly the cycle after a grant, and rsp_id carries the granted ID.
- R4: A load returns the addressed word. A store writes the write data and returns the previous word.
- R5: Test-and-set returns the old word and writes 1 only when that old word is 0. Otherwise memory is unchanged.
- R6: Swap writes the supplied data and returns the word that was there before.
- R7: Load-reserved returns the addressed word and sets the requester's reservation together with the address.
- R8: In address mode, a store-conditional succeeds only if the requester's reservation is set and its reserved address equals the request address. On success it writes memory and returns status 0 with rdata 0.
- R9: A failed store-conditional leaves memory unchanged and returns status 1 with rdata 0. Only a store-conditional ever returns status 1.
- R10: A store-conditional clears the issuing requester's own reservation whether it succeeds or fails.
- R11: In address mode, any write by another requester (store, swap, test-and-set that writes, successful store-conditional) to the reserved address clears the reservation. A write to a different address does not.
- R12: With resv_flag_only high, any write by another requester clears the reservation whatever the address, and a store-conditional ignores the address and succeeds whenever the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resv_flag_only | input | 1 | 1: reservations are flags only; 0: address-matched |
| req_valid | input | NUM_REQ | Request valid per requester |
| req_op | input | NUM_REQ*3 | Opcode per requester, packed by ID |
| req_addr | input | NUM_REQ*ADDR_W | Word address per requester |
| req_wdata | input | NUM_REQ*DATA_W | Write data per requester |
| req_grant | output | NUM_REQ | One-hot grant, same cycle as request |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | $clog2(NUM_REQ) | ID of the answered requester |
| rsp_rdata | output | DATA_W | Old word, or 0 for store-conditional |
| rsp_status | output | 1 | Store-conditional status: 0 success, 1 failure |

## Verification
The bench targets the cases where reservation handling breaks.

- **Second conditional store.** A store-conditional is issued a second time after a success. A design that forgets to clear the issuer's own flag would let that second store succeed.
- **Competing reservations.** Two requesters reserve the same word and one of them commits. A design that does not cancel the loser would let both commit.
- **Foreign writes in address mode.** Writes from other requesters hit either a different address or the reserved one. A design that clears the flag on every write, or on none, misjudges one of these two cases.
- **Flag-only mode.** The bench repeats the foreign-write case in flag-only mode, and also issues a store-conditional to an address other than the reserved one.
- **Arbitration and atomic operations.** Simultaneous requests expose inverted priority. Test-and-set is issued on zero and on non-zero words, where a wrong design would overwrite a set word.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_TAS   = 3'd2,
        OP_SWAP  = 3'd3,
        OP_LR    = 3'd4,
        OP_SC    = 3'd5
    } amo_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } amo_state_e;

    localparam int OP_W = 3;
    localparam logic SC_PASS = 1'b0;
    localparam logic SC_FAIL = 1'b1;

endpackage

// File: rtl/amo_arbiter.sv
module amo_arbiter #(
    parameter int NUM_REQ = 4,
    localparam int ID_W = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] valid,
    output logic [NUM_REQ-1:0] grant,
    output logic               any,
    output logic [ID_W-1:0]    win_id
);

    always_comb begin
        grant  = '0;
        win_id = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (valid[i]) begin
                win_id = ID_W'(i);
            end
        end
        any = |valid;
        if (any) begin
            grant[win_id] = 1'b1;
        end
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R2
    grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid[0] |-> grant[0]);
    // R2
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~valid) == '0);

endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] words [DEPTH];

    assign rd_data = words[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            words[addr] <= wr_data;
        end
    end

endmodule

// File: rtl/amo_resv_table.sv
module amo_resv_table #(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W = 4,
    localparam int ID_W = $clog2(NUM_REQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_only,
    input  logic              lr_set,
    input  logic              sc_evt,
    input  logic              wr_evt,
    input  logic [ID_W-1:0]   id,
    input  logic [ADDR_W-1:0] addr,
    output logic              sc_ok
);

    logic [NUM_REQ-1:0] held;
    logic [ADDR_W-1:0]  held_addr [NUM_REQ];

    assign sc_ok = held[id] && (flag_only || held_addr[id] == addr);

    generate
        for (genvar j = 0; j < NUM_REQ; j++) begin : g_slot
            logic mine;
            logic hit;
            assign mine = (id == ID_W'(j));
            assign hit  = flag_only || held_addr[j] == addr;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    held[j]      <= 1'b0;
                    held_addr[j] <= '0;
                end else if (lr_set && mine) begin
                    held[j]      <= 1'b1;
                    held_addr[j] <= addr;
                end else if (sc_evt && mine) begin
                    held[j] <= 1'b0;
                end else if (wr_evt && !mine && hit) begin
                    held[j] <= 1'b0;
                end
            end

            // R10
            own_sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sc_evt && mine) |=> !held[j]);
            // R12
            foreign_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_evt && flag_only && !mine) |=> !held[j]);
        end
    endgenerate

endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int ID_W = $clog2(NUM_REQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      resv_flag_only,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ*OP_W-1:0]   req_op,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
    input  logic [NUM_REQ*DATA_W-1:0] req_wdata,
    output logic [NUM_REQ-1:0]        req_grant,
    output logic                      rsp_valid,
    output logic [ID_W-1:0]           rsp_id,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic                      rsp_status
);

    amo_state_e        state;
    logic              acc;
    logic [ID_W-1:0]   sel_id;
    amo_op_e           sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic [DATA_W-1:0] old_word;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic              lr_set;
    logic              sc_evt;
    logic              sc_ok;
    logic [DATA_W-1:0] nxt_rdata;
    logic              nxt_status;

    amo_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (req_valid),
        .grant  (req_grant),
        .any    (acc),
        .win_id (sel_id)
    );

    assign sel_op    = amo_op_e'(req_op[sel_id*OP_W +: OP_W]);
    assign sel_addr  = req_addr[sel_id*ADDR_W +: ADDR_W];
    assign sel_wdata = req_wdata[sel_id*DATA_W +: DATA_W];

    amo_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (sel_addr),
        .rd_data (old_word),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );

    amo_resv_table #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_only (resv_flag_only),
        .lr_set    (lr_set),
        .sc_evt    (sc_evt),
        .wr_evt    (wr_en),
        .id        (sel_id),
        .addr      (sel_addr),
        .sc_ok     (sc_ok)
    );

    // Operation decode: what to write and what to answer.
    always_comb begin
        wr_en      = 1'b0;
        wr_data    = sel_wdata;
        lr_set     = 1'b0;
        sc_evt     = 1'b0;
        nxt_rdata  = old_word;
        nxt_status = SC_PASS;
        if (acc) begin
            unique case (sel_op)
                OP_STORE: wr_en = 1'b1;
                OP_TAS: begin
                    if (old_word == '0) begin
                        wr_en   = 1'b1;
                        wr_data = DATA_W'(1);
                    end
                end
                OP_SWAP: wr_en = 1'b1;
                OP_LR:   lr_set = 1'b1;
                OP_SC: begin
                    sc_evt    = 1'b1;
                    nxt_rdata = '0;
                    if (sc_ok) begin
                        wr_en = 1'b1;
                    end else begin
                        nxt_status = SC_FAIL;
                    end
                end
                default: ;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state <= acc ? ST_RESP : ST_IDLE;
                ST_RESP: state <= acc ? ST_RESP : ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Response outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_id     <= '0;
            rsp_rdata  <= '0;
            rsp_status <= SC_PASS;
        end else if (acc) begin
            rsp_id     <= sel_id;
            rsp_rdata  <= nxt_rdata;
            rsp_status <= nxt_status;
        end
    end

    assign rsp_valid = (state == ST_RESP);

    // R3
    accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    // R3
    rsp_has_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc));
    // R9
    fail_only_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status) |-> ($past(sel_op) == OP_SC && rsp_rdata == '0));
    // R5
    tas_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sel_op == OP_TAS && old_word != '0) |-> !wr_en);

endmodule

// File: tb/amo_unit_test.sv
module amo_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int AW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          resv_flag_only = 1'b0;
    logic [N-1:0]  req_valid = '0;
    logic [N*3-1:0]  req_op = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*DW-1:0] req_wdata = '0;
    logic [N-1:0]  req_grant;
    logic          rsp_valid;
    logic [1:0]    rsp_id;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          id;
        logic [DW-1:0] rdata;
        logic        status;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [DW-1:0] mm [16];
    bit            flg [N];
    int            rad [N];

    amo_unit uut (
        .clk(clk), .rst_n(rst_n), .resv_flag_only(resv_flag_only),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_grant(req_grant), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // Reference model write: other requesters lose matching reservations.
    task automatic model_write(input int id, input int a, input logic [DW-1:0] d);
        mm[a] = d;
        for (int j = 0; j < N; j++) begin
            if (j != id && flg[j] && (resv_flag_only || rad[j] == a)) flg[j] = 0;
        end
    endtask

    task automatic expect_for(input int id, input logic [2:0] op, input int a,
                              input logic [DW-1:0] wd, input string tag);
        exp_t e;
        logic [DW-1:0] old;
        bit ok;
        old = mm[a];
        e.id = id; e.rdata = old; e.status = 1'b0; e.tag = tag;
        case (op)
            3'd1: model_write(id, a, wd);
            3'd2: if (old == '0) model_write(id, a, DW'(1));
            3'd3: model_write(id, a, wd);
            3'd4: begin flg[id] = 1; rad[id] = a; end
            3'd5: begin
                ok = flg[id] && (resv_flag_only || rad[id] == a);
                flg[id] = 0;
                e.rdata = '0;
                if (ok) model_write(id, a, wd);
                else e.status = 1'b1;
            end
            default: ;
        endcase
        q.push_back(e);
    endtask

    task automatic issue(input int id, input logic [2:0] op, input int a,
                         input logic [DW-1:0] wd, input string tag);
        @(negedge clk);
        req_valid[id] = 1'b1;
        req_op[id*3 +: 3] = op;
        req_addr[id*AW +: AW] = AW'(a);
        req_wdata[id*DW +: DW] = wd;
        #1;
        check(req_grant == N'(1 << id), {tag, " grant"},
              $sformatf("%b", req_grant), $sformatf("%b", N'(1 << id)));
        expect_for(id, op, a, wd, tag);
        @(posedge clk);
        #1;
        req_valid[id] = 1'b0;
    endtask

    // Monitor: pops the scoreboard as responses appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                check(rsp_valid && rsp_id == 2'(e.id) && rsp_rdata == e.rdata &&
                      rsp_status == e.status, e.tag,
                      $sformatf("v=%0b id=%0d d=%h s=%0b", rsp_valid, rsp_id, rsp_rdata, rsp_status),
                      $sformatf("v=1 id=%0d d=%h s=%0b", e.id, e.rdata, e.status));
            end else if (rsp_valid) begin
                check(1'b0, "R3 unexpected response", "rsp_valid=1", "rsp_valid=0");
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) mm[i] = '0;
        for (int i = 0; i < N; i++) begin flg[i] = 0; rad[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0 && req_grant == '0, "R1 reset outputs",
              $sformatf("v=%0b g=%b", rsp_valid, req_grant), "v=0 g=0000");
        rst_n = 1'b1;

        // R1: first conditional store fails; memory reads zero
        issue(0, 3'd5, 0, 16'h1111, "R1 sc after reset");
        issue(2, 3'd0, 5, 16'h0, "R1 load zero");
        // R4
        issue(1, 3'd1, 3, 16'h1234, "R4 store");
        issue(2, 3'd0, 3, 16'h0, "R4 load");
        issue(3, 3'd6, 3, 16'h0, "R4 spare code loads");
        // R5
        issue(0, 3'd2, 7, 16'h0, "R5 tas on zero");
        issue(1, 3'd2, 7, 16'h0, "R5 tas on one");
        issue(2, 3'd1, 7, 16'h0005, "R5 setup store");
        issue(0, 3'd2, 7, 16'h0, "R5 tas on five");
        issue(1, 3'd0, 7, 16'h0, "R5 word kept");
        // R6
        issue(3, 3'd3, 3, 16'hBEEF, "R6 swap");
        issue(0, 3'd0, 3, 16'h0, "R6 swapped word");
        // R7, R8
        issue(0, 3'd0, 9, 16'h0, "R7 pre");
        issue(0, 3'd4, 9, 16'h0, "R7 reserve");
        issue(0, 3'd5, 9, 16'h0055, "R8 sc success");
        issue(1, 3'd0, 9, 16'h0, "R8 sc wrote");
        // R10
        issue(0, 3'd5, 9, 16'h0077, "R10 second sc fails");
        issue(1, 3'd0, 9, 16'h0, "R9 memory kept");
        // R8 address mismatch
        issue(2, 3'd4, 12, 16'h0, "R8 reserve 12");
        issue(2, 3'd5, 13, 16'h0099, "R8 sc other addr fails");
        // R11
        issue(1, 3'd4, 10, 16'h0, "R11 reserve");
        issue(2, 3'd1, 11, 16'h00AA, "R11 store elsewhere");
        issue(1, 3'd5, 10, 16'h00BB, "R11 sc survives");
        issue(1, 3'd4, 10, 16'h0, "R11 reserve again");
        issue(2, 3'd3, 10, 16'h00CC, "R11 foreign swap");
        issue(1, 3'd5, 10, 16'h00DD, "R11 sc cancelled");
        issue(3, 3'd0, 10, 16'h0, "R9 value after fail");
        issue(0, 3'd4, 4, 16'h0, "R11 reserve a");
        issue(1, 3'd4, 4, 16'h0, "R11 reserve b");
        issue(0, 3'd5, 4, 16'h0042, "R11 first sc wins");
        issue(1, 3'd5, 4, 16'h0043, "R11 loser fails");
        // R12
        @(negedge clk);
        resv_flag_only = 1'b1;
        issue(3, 3'd4, 1, 16'h0, "R12 reserve");
        issue(0, 3'd1, 2, 16'h0101, "R12 store elsewhere");
        issue(3, 3'd5, 1, 16'h0202, "R12 sc cancelled");
        issue(3, 3'd4, 1, 16'h0, "R12 reserve again");
        issue(3, 3'd5, 6, 16'h0303, "R12 sc other addr ok");
        issue(2, 3'd0, 6, 16'h0, "R12 wrote 6");
        @(negedge clk);
        resv_flag_only = 1'b0;

        // R2: concurrent requests, lowest ID first
        @(negedge clk);
        req_valid[1] = 1'b1; req_op[3 +: 3] = 3'd0; req_addr[AW +: AW] = 4'd3;
        req_valid[3] = 1'b1; req_op[9 +: 3] = 3'd0; req_addr[3*AW +: AW] = 4'd9;
        #1;
        check(req_grant == 4'b0010, "R2 lowest first", $sformatf("%b", req_grant), "0010");
        expect_for(1, 3'd0, 3, 16'h0, "R2 id1 answer");
        @(posedge clk); #1;
        req_valid[1] = 1'b0;
        @(negedge clk); #1;
        check(req_grant == 4'b1000, "R2 stalled served", $sformatf("%b", req_grant), "1000");
        expect_for(3, 3'd0, 9, 16'h0, "R2 id3 answer");
        @(posedge clk); #1;
        req_valid[3] = 1'b0;

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R3 all answered", $sformatf("%0d", q.size()), "0");
        finish_run();
    end

endmodule